// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This block carries out the test-and-skip class of operate micro-instructions for a 12-bit accumulator machine. In one instruction it can check the accumulator and the link against a selected condition and decide whether the next sequential instruction is skipped. In the same instruction it can also clear the accumulator, merge in the front-panel switch value, and ask the machine to stop.

A sequencer raises `op_strobe` for one cycle and presents the decoded instruction fields together with the current accumulator, link and switch value. One clock later the block presents the new accumulator, a skip flag and a halt pulse, and `res_valid` marks that cycle. The sequencer uses the skip flag to advance the program counter by one extra word. The skip test always looks at the accumulator and link as they were before the instruction changed them. Clearing is applied before the switch merge, so asking for both loads the switch value into the accumulator.

Top module: `skip_unit`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, `ac_out` is 0 and `skip_out`, `halt_out`, `cond_err` and `res_valid` are 0.
- R2: An instruction presented with `op_strobe` high at a rising edge gives its results at that edge, so they can be read in the following cycle with `res_valid` at 1. In a cycle after an edge where `op_strobe` was low, `res_valid`, `skip_out`, `halt_out` and `cond_err` are 0 and `ac_out` keeps its value.
- R3: `cond_sel` selects the skip condition, one bit for each condition. Bit 0 skips unconditionally, bit 1 skips when the link is 1, bit 2 when the link is 0, bit 3 when the AC is zero, bit 4 when the AC is non-zero, bit 5 when the AC is negative, and bit 6 when the AC is positive. `skip_out` is 1 exactly when the selected condition holds.
- R4: The AC counts as negative when bit 11 is 1 and as positive when bit 11 is 0, so an AC of zero counts as positive.
- R5: If more than one bit of `cond_sel` is set, `cond_err` is 1 and `skip_out` is 0. If no bit is set, both are 0.
- R6: The new AC is the incoming AC, replaced by zero when `op_cla` is set, then ORed with `sw_in` when `op_osr` is set. Setting both therefore loads `sw_in` into the AC.
- R7: The skip decision is made on the incoming `ac_in` and `link_in`, whatever `op_cla` and `op_osr` do to the AC in the same instruction.
- R8: `halt_out` is 1 for exactly one cycle for each strobed instruction that has `op_hlt` set, and it is 0 otherwise.
- R9: Clear, switch merge, halt and one skip condition can all be requested together, and each of them then behaves as it would on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_strobe | input | 1 | An instruction is presented this cycle |
| ac_in | input | 12 | Accumulator before the instruction |
| link_in | input | 1 | Link before the instruction |
| sw_in | input | 12 | Switch register value |
| cond_sel | input | 7 | Skip condition select, one bit for each condition |
| op_cla | input | 1 | Clear the accumulator |
| op_osr | input | 1 | OR the switch value into the accumulator |
| op_hlt | input | 1 | Request a halt |
| ac_out | output | 12 | Updated accumulator |
| skip_out | output | 1 | Skip the next sequential instruction |
| halt_out | output | 1 | Halt request pulse |
| cond_err | output | 1 | More than one skip condition was selected |
| res_valid | output | 1 | The outputs hold an instruction's result |

## Verification
The skip decision and the accumulator rewrite happen in the same instruction, and they use different versions of the AC. A wrong order only shows up when both are requested together. The bench drives directed instructions that test for a zero or negative AC while also clearing it or ORing in switches that would turn the answer the other way. It also sends random instructions that mix all four operations. It judges each result against bench functions that compute the skip from the pre-instruction AC and the link, and the AC from the clear-then-OR rule.

// File: rtl/skip_unit_pkg.sv
package skip_unit_pkg;

  localparam int unsigned COND_NUM = 7;

  // bit positions of the condition select vector
  typedef enum int unsigned {
    C_ALWAYS   = 0,
    C_LINK_SET = 1,
    C_LINK_CLR = 2,
    C_AC_ZERO  = 3,
    C_AC_NZERO = 4,
    C_AC_NEG   = 5,
    C_AC_POS   = 6
  } cond_idx_e;

  // truth of one condition, given the flags taken from the incoming AC and link
  function automatic logic cond_test(int unsigned idx, logic ac_is_zero,
                                     logic ac_sign, logic link);
    logic r;
    case (idx)
      C_ALWAYS:   r = 1'b1;
      C_LINK_SET: r = link;
      C_LINK_CLR: r = ~link;
      C_AC_ZERO:  r = ac_is_zero;
      C_AC_NZERO: r = ~ac_is_zero;
      C_AC_NEG:   r = ac_sign;
      C_AC_POS:   r = ~ac_sign;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  // more than one select bit set: clearing the lowest set bit leaves some bit set
  function automatic logic multi_hot(logic [COND_NUM-1:0] sel);
    return |(sel & (sel - COND_NUM'(1)));
  endfunction

endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
  import skip_unit_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0]        ac,
  input  logic                link,
  input  logic [COND_NUM-1:0] sel,
  output logic [COND_NUM-1:0] hit_vec,
  output logic                multi,
  output logic                take
);
  logic ac_is_zero;
  logic ac_sign;

  assign ac_is_zero = (ac == '0);
  assign ac_sign    = ac[W-1];

  for (genvar i = 0; i < COND_NUM; i++) begin : g_cond
    assign hit_vec[i] = sel[i] & cond_test(i, ac_is_zero, ac_sign, link);
  end

  assign multi = multi_hot(sel);
  assign take  = (|hit_vec) & ~multi;
endmodule

// File: rtl/skip_ac_path.sv
module skip_ac_path #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] ac,
  input  logic [W-1:0] sw,
  input  logic         cla,
  input  logic         osr,
  output logic [W-1:0] ac_next
);
  logic [W-1:0] ac_cleared;

  // clear first, then merge the switches
  assign ac_cleared = cla ? '0 : ac;
  assign ac_next    = ac_cleared | (osr ? sw : '0);
endmodule

// File: rtl/skip_unit.sv
module skip_unit
  import skip_unit_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_strobe,
  input  logic [W-1:0]        ac_in,
  input  logic                link_in,
  input  logic [W-1:0]        sw_in,
  input  logic [COND_NUM-1:0] cond_sel,
  input  logic                op_cla,
  input  logic                op_osr,
  input  logic                op_hlt,
  output logic [W-1:0]        ac_out,
  output logic                skip_out,
  output logic                halt_out,
  output logic                cond_err,
  output logic                res_valid
);
  logic [COND_NUM-1:0] hit_w;
  logic                multi_w;
  logic                take_w;
  logic [W-1:0]        ac_next_w;

  skip_cond_eval #(.W(W)) u_cond (
    .ac      (ac_in),
    .link    (link_in),
    .sel     (cond_sel),
    .hit_vec (hit_w),
    .multi   (multi_w),
    .take    (take_w)
  );

  skip_ac_path #(.W(W)) u_acp (
    .ac      (ac_in),
    .sw      (sw_in),
    .cla     (op_cla),
    .osr     (op_osr),
    .ac_next (ac_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_out    <= '0;
      skip_out  <= 1'b0;
      halt_out  <= 1'b0;
      cond_err  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_strobe;
      skip_out  <= op_strobe & take_w;
      halt_out  <= op_strobe & op_hlt;
      cond_err  <= op_strobe & multi_w;
      if (op_strobe) ac_out <= ac_next_w;
    end
  end
endmodule

// File: rtl/skip_unit_chk.sv
module skip_unit_chk
  import skip_unit_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                op_strobe,
  input logic [W-1:0]        ac_in,
  input logic [COND_NUM-1:0] cond_sel,
  input logic                op_cla,
  input logic                op_osr,
  input logic                op_hlt,
  input logic [W-1:0]        ac_out,
  input logic                skip_out,
  input logic                halt_out,
  input logic                cond_err,
  input logic                res_valid,
  input logic                multi_w
);
  // R2: idle cycles carry no result
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!skip_out && !halt_out && !cond_err));

  // R2: accumulator holds across an idle edge
  a_r2_ac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_strobe |=> $stable(ac_out));

  // R5: an error never comes with a skip
  a_r5_err_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    cond_err |-> !skip_out);

  // R5: an error follows a strobed instruction with a multi-bit select
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && multi_w) |=> cond_err);

  // R8: halt only follows a strobed halt request
  a_r8_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_out |-> $past(op_strobe && op_hlt));

  // R6: clear without merge gives zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && op_cla && !op_osr) |=> (ac_out == '0));

  // R3: unconditional select always skips
  a_r3_always_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && cond_sel == COND_NUM'(1)) |=> skip_out);

  // R7: zero test uses the incoming AC even when it is rewritten
  a_r7_zero_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (op_strobe && cond_sel == (COND_NUM'(1) << C_AC_ZERO) && ac_in == '0) |=> skip_out);
endmodule

bind skip_unit skip_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_strobe (op_strobe),
  .ac_in     (ac_in),
  .cond_sel  (cond_sel),
  .op_cla    (op_cla),
  .op_osr    (op_osr),
  .op_hlt    (op_hlt),
  .ac_out    (ac_out),
  .skip_out  (skip_out),
  .halt_out  (halt_out),
  .cond_err  (cond_err),
  .res_valid (res_valid),
  .multi_w   (multi_w)
);

// File: tb/tb_skip_unit.sv
module tb_skip_unit;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 12;
  localparam int unsigned NC = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_strobe = 1'b0;
  logic [W-1:0]  ac_in = '0;
  logic          link_in = 1'b0;
  logic [W-1:0]  sw_in = '0;
  logic [NC-1:0] cond_sel = '0;
  logic          op_cla = 1'b0, op_osr = 1'b0, op_hlt = 1'b0;
  logic [W-1:0]  ac_out;
  logic          skip_out, halt_out, cond_err, res_valid;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] exp_ac = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .ac_in(ac_in),
    .link_in(link_in), .sw_in(sw_in), .cond_sel(cond_sel), .op_cla(op_cla),
    .op_osr(op_osr), .op_hlt(op_hlt), .ac_out(ac_out), .skip_out(skip_out),
    .halt_out(halt_out), .cond_err(cond_err), .res_valid(res_valid)
  );

  // reference: count the select bits, then test each condition on the pre-instruction state
  function automatic logic ref_skip(logic [NC-1:0] s, logic [W-1:0] a, logic l);
    int ones = 0;
    logic ok = 1'b0;
    for (int k = 0; k < NC; k++) ones += int'(s[k]);
    if (ones != 1) return 1'b0;
    if (s[0]) ok = 1'b1;
    if (s[1]) ok = (l == 1'b1);
    if (s[2]) ok = (l == 1'b0);
    if (s[3]) ok = (a == 0);
    if (s[4]) ok = (a != 0);
    if (s[5]) ok = (a >= 12'h800);
    if (s[6]) ok = (a < 12'h800);
    return ok;
  endfunction

  function automatic logic ref_err(logic [NC-1:0] s);
    return $countones(s) > 1;
  endfunction

  function automatic logic [W-1:0] ref_ac(logic [W-1:0] a, logic [W-1:0] sw, logic c, logic o);
    logic [W-1:0] r = a;
    if (c) r = '0;
    if (o) r = r | sw;
    return r;
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // present one instruction at a falling edge; check at the next falling edge
  task automatic issue(string req, logic [NC-1:0] s, logic [W-1:0] a, logic l,
                       logic [W-1:0] sw, logic c, logic o, logic h);
    logic es, ee;
    op_strobe = 1'b1; cond_sel = s; ac_in = a; link_in = l; sw_in = sw;
    op_cla = c; op_osr = o; op_hlt = h;
    es = ref_skip(s, a, l);
    ee = ref_err(s);
    exp_ac = ref_ac(a, sw, c, o);
    @(negedge clk);
    op_strobe = 1'b0;
    check(req, "valid", W'(res_valid), W'(1));
    check(req, "ac", ac_out, exp_ac);
    check(req, "skip", W'(skip_out), W'(es));
    check(req, "err", W'(cond_err), W'(ee));
    check("R8", "halt", W'(halt_out), W'(h));
  endtask

  task automatic idle_check();
    op_strobe = 1'b0;
    ac_in = W'($urandom); cond_sel = 7'h7f; op_hlt = 1'b1;
    @(negedge clk);
    check("R2", "idle valid", W'(res_valid), W'(0));
    check("R2", "idle skip", W'(skip_out), W'(0));
    check("R8", "idle halt", W'(halt_out), W'(0));
    check("R2", "idle err", W'(cond_err), W'(0));
    check("R2", "idle ac hold", ac_out, exp_ac);
    op_hlt = 1'b0; cond_sel = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset ac", ac_out, '0);
    check("R1", "reset flags", W'({skip_out, halt_out, cond_err, res_valid}), W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-release flags", W'({skip_out, halt_out, cond_err, res_valid}), W'(0));

    // R3 each condition, true and false
    issue("R3", 7'b0000001, 12'h123, 1'b0, 12'h000, 0, 0, 0);
    issue("R3", 7'b0000010, 12'h000, 1'b1, 12'h000, 0, 0, 0);
    issue("R3", 7'b0000010, 12'h000, 1'b0, 12'h000, 0, 0, 0);
    issue("R3", 7'b0000100, 12'h001, 1'b0, 12'h000, 0, 0, 0);
    issue("R3", 7'b0000100, 12'h001, 1'b1, 12'h000, 0, 0, 0);
    issue("R3", 7'b0001000, 12'h000, 1'b0, 12'h000, 0, 0, 0);
    issue("R3", 7'b0010000, 12'h000, 1'b0, 12'h000, 0, 0, 0);
    issue("R3", 7'b0010000, 12'h400, 1'b0, 12'h000, 0, 0, 0);
    // R4 sign boundaries; zero counts as positive
    issue("R4", 7'b0100000, 12'h800, 1'b0, 12'h000, 0, 0, 0);
    issue("R4", 7'b0100000, 12'h7ff, 1'b0, 12'h000, 0, 0, 0);
    issue("R4", 7'b1000000, 12'h000, 1'b0, 12'h000, 0, 0, 0);
    issue("R4", 7'b1000000, 12'hfff, 1'b0, 12'h000, 0, 0, 0);
    // R5 multiple and none
    issue("R5", 7'b0001001, 12'h000, 1'b0, 12'h000, 0, 0, 0);
    issue("R5", 7'b1111111, 12'h000, 1'b1, 12'h000, 0, 0, 0);
    issue("R5", 7'b0000000, 12'h000, 1'b1, 12'h000, 0, 0, 0);
    // R6 clear, merge, load switches
    issue("R6", 7'b0, 12'h5a5, 1'b0, 12'h0f0, 1, 0, 0);
    issue("R6", 7'b0, 12'h5a5, 1'b0, 12'h0f0, 0, 1, 0);
    issue("R6", 7'b0, 12'h5a5, 1'b0, 12'h0f0, 1, 1, 0);
    // R7 skip judged on the pre-instruction AC
    issue("R7", 7'b0001000, 12'h000, 1'b0, 12'hfff, 0, 1, 0);
    issue("R7", 7'b0010000, 12'h321, 1'b0, 12'h000, 1, 0, 0);
    issue("R7", 7'b1000000, 12'h100, 1'b0, 12'h800, 1, 1, 0);
    // R8 / R9 everything together, then back-to-back halts
    issue("R9", 7'b0100000, 12'h900, 1'b1, 12'h00f, 1, 1, 1);
    issue("R8", 7'b0, 12'h000, 1'b0, 12'h000, 0, 0, 1);
    issue("R8", 7'b0, 12'h000, 1'b0, 12'h000, 0, 0, 1);
    idle_check();
    idle_check();

    // R9 random mix, occasional idle cycles
    for (int n = 0; n < 400; n++) begin
      logic [NC-1:0] s;
      int pick = int'($urandom_range(0, 9));
      if (pick < 6) s = NC'(1) << $urandom_range(0, NC-1);
      else if (pick < 8) s = NC'($urandom);
      else s = '0;
      issue("R9", s, ($urandom_range(0, 3) == 0) ? W'(0) : W'($urandom), 1'($urandom),
            W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 4) == 0) idle_check();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule